// File: doc/BRIEF.md
# Serial Display Bring-Up Sequencer

This block sits on the host side of a serial link to a small display controller and brings the controller into operation without any software involvement. A pulse on `start_i` makes it first identify the controller. It selects the device-code register and reads it back. If the upper twelve bits do not match the expected code, the block stops and raises `err_o`. If they match, it replays a fixed list of register writes from an internal step table. The list covers panel configuration, the analog power ramp with its settling pauses and the gamma curve. It ends by selecting the pixel-memory write register, so that a later pixel stream lands in display memory.

Every register write becomes two separate serial frames, each framed by its own chip-select low period. The first frame carries the register index and the second carries the 16-bit value. A pulse on `pwr_off_i` plays a short shutdown list through the same machinery. Millisecond pauses come from a single clock-cycles-per-millisecond parameter, so a bench can shorten them. An input selects whether every transmitted byte is sent complemented, for links that invert the data line.

Top module: `disp_init_seq`

## Requirements
- R1: After reset `busy_o`, `done_o` and `err_o` are low, `cs_n_o` is high and `sclk_o` is low.
- R2: A start request first sends an index frame {S(0,0), 0x00, 0x00} and then a read frame {S(1,1), 0x00, 0x00}. The start byte is S(rs,rw) = 0x70 | (CHIP_ID_BIT<<2) | (rs<<1) | rw. Every frame is three bytes, most significant bit first, and the read value is the last 16 bits received.
- R3: The read value ANDed with 0xFFF0 must equal 0x9220. Otherwise `err_o` rises, `busy_o` falls and no further frame is sent.
- R4: A register write is an index frame {S(0,0), 0x00, index} followed by a data frame {S(1,0), value[15:8], value[7:0]}, each in its own chip-select low period.
- R5: After a good probe the list runs strictly in order. It starts with 0x0001 to register 0x00. It includes 0x080F to register 0x56 between the two power-ramp halves. It ends with an index-only frame {S(0,0), 0x00, 0x22}, for 77 frames in total including the probe.
- R6: After a write to register 0x00 or 0x10, at least 10 ms pass from chip-select release to the next chip-select fall. After a write to 0x12 or 0x13 the pause is at least 40 ms. A millisecond is CLK_PER_MS clock cycles. Other writes add no millisecond pause.
- R7: A power-off request sends 0x0000 to registers 0x10, 0x11, 0x12 and 0x13 in that order, with the R6 pauses, and then raises `done_o`.
- R8: The serial clock idles low while chip select is high. MOSI changes only while SCLK is low. Each SCLK level lasts at least SCLK_HALF clock cycles, so the default keeps SCLK at or below 4 MHz from a 100 MHz clock.
- R9: When `tx_inv_i` is high at the request, every transmitted byte of that run is sent bitwise complemented. Received data is not inverted.
- R10: Start and power-off requests that arrive while `busy_o` is high are ignored. Chip select is only driven low while `busy_o` is high.
- R11: `done_o` and `err_o` are levels that are never high together. Both clear when a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request probe and full bring-up |
| pwr_off_i | input | 1 | Request shutdown list |
| tx_inv_i | input | 1 | Complement transmitted bytes for the coming run |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Last run completed normally |
| err_o | output | 1 | Device code mismatch on last probe |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to the controller |
| miso_i | input | 1 | Serial data from the controller |

## Verification
A wrong step pointer or a skipped step table read shows at the serial port within a frame as a wrong index or value byte, and the frame count at `done_o` comes out different from 77. A wait counter that loads the wrong code shows as a chip-select gap that is too short or too long, visible at the next chip-select fall. A bad compare or a bad capture of the received bits shows as `err_o` on a good device, or as the sequence running on after a bad code, two frames after the start. An inversion fault shows in the very first byte of the run.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;

  typedef enum logic [1:0] {
    WT_NONE  = 2'd0,
    WT_SHORT = 2'd1,
    WT_LONG  = 2'd2
  } wait_e;

  typedef struct packed {
    logic        last;
    logic        idx_only;
    wait_e       wt;
    logic [7:0]  idx;
    logic [15:0] val;
  } step_t;

  localparam int STEP_AW     = 6;
  localparam int PWROFF_BASE = 38;
  localparam int SHORT_MS    = 10;
  localparam int LONG_MS     = 40;
  localparam int FRAME_BITS  = 24;

  localparam logic [15:0] CODE_EXPECT = 16'h9220;
  localparam logic [15:0] CODE_MASK   = 16'hFFF0;
  localparam logic [7:0]  GRAM_SEL    = 8'h22;

  // pause owed after a write depends only on the register index
  function automatic wait_e wait_rule(input logic [7:0] idx);
    case (idx)
      8'h00, 8'h10: return WT_SHORT;
      8'h12, 8'h13: return WT_LONG;
      default:      return WT_NONE;
    endcase
  endfunction

  function automatic step_t wr(input logic [7:0] idx, input logic [15:0] v);
    step_t s;
    s.last     = 1'b0;
    s.idx_only = 1'b0;
    s.wt       = wait_rule(idx);
    s.idx      = idx;
    s.val      = v;
    return s;
  endfunction

  function automatic logic [7:0] start_byte(input logic id, input logic rs, input logic rw);
    return 8'h70 | {5'b0, id, rs, rw};
  endfunction

endpackage

// File: rtl/disp_seq_rom.sv
module disp_seq_rom
  import disp_seq_pkg::*;
(
  input  logic               clk,
  input  logic [STEP_AW-1:0] addr,
  output step_t              q
);

  step_t d;

  always_comb begin
    case (addr)
      // panel configuration
      6'd0:  d = wr(8'h00, 16'h0001);
      6'd1:  d = wr(8'h01, 16'h691B);
      6'd2:  d = wr(8'h02, 16'h0700);
      6'd3:  d = wr(8'h03, 16'h1030);
      6'd4:  d = wr(8'h04, 16'h0000);
      6'd5:  d = wr(8'h05, 16'h0000);
      6'd6:  d = wr(8'h07, 16'h0037);
      6'd7:  d = wr(8'h08, 16'h0202);
      6'd8:  d = wr(8'h09, 16'h0000);
      6'd9:  d = wr(8'h0B, 16'h0000);
      6'd10: d = wr(8'h0C, 16'h0110);
      // power ramp, first half clears, second half programs
      6'd11: d = wr(8'h10, 16'h0000);
      6'd12: d = wr(8'h11, 16'h0000);
      6'd13: d = wr(8'h12, 16'h0000);
      6'd14: d = wr(8'h13, 16'h0000);
      6'd15: d = wr(8'h56, 16'h080F);
      6'd16: d = wr(8'h10, 16'h4240);
      6'd17: d = wr(8'h11, 16'h0000);
      6'd18: d = wr(8'h12, 16'h0014);
      6'd19: d = wr(8'h13, 16'h1319);
      // gamma curve
      6'd20: d = wr(8'h30, 16'h0302);
      6'd21: d = wr(8'h31, 16'h0407);
      6'd22: d = wr(8'h32, 16'h0304);
      6'd23: d = wr(8'h33, 16'h0203);
      6'd24: d = wr(8'h34, 16'h0706);
      6'd25: d = wr(8'h35, 16'h0407);
      6'd26: d = wr(8'h36, 16'h0706);
      6'd27: d = wr(8'h37, 16'h0000);
      6'd28: d = wr(8'h38, 16'h0C06);
      6'd29: d = wr(8'h39, 16'h0F00);
      // addressing and scan window
      6'd30: d = wr(8'h21, 16'h0000);
      6'd31: d = wr(8'h40, 16'h0000);
      6'd32: d = wr(8'h41, 16'h0000);
      6'd33: d = wr(8'h42, 16'hDB00);
      6'd34: d = wr(8'h43, 16'hDB00);
      6'd35: d = wr(8'h44, 16'hAF00);
      6'd36: d = wr(8'h45, 16'hDB00);
      6'd37: begin
        d          = wr(GRAM_SEL, 16'h0000);
        d.idx_only = 1'b1;
        d.last     = 1'b1;
      end
      // shutdown list
      6'd38: d = wr(8'h10, 16'h0000);
      6'd39: d = wr(8'h11, 16'h0000);
      6'd40: d = wr(8'h12, 16'h0000);
      6'd41: begin
        d      = wr(8'h13, 16'h0000);
        d.last = 1'b1;
      end
      default: d = '0;
    endcase
  end

  // registered read so the table maps onto a synchronous memory
  always_ff @(posedge clk) q <= d;

endmodule

// File: rtl/disp_wait_timer.sv
module disp_wait_timer
  import disp_seq_pkg::*;
#(
  parameter int CLK_PER_MS = 100000
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  go_i,
  input  wait_e code_i,
  output logic  busy_o
);

  localparam int CW  = $clog2(CLK_PER_MS + 1);
  localparam int MSW = $clog2(LONG_MS + 1);
  localparam logic [CW-1:0] CYC_LAST = CW'(CLK_PER_MS - 1);

  logic [CW-1:0]  cyc;
  logic [MSW-1:0] ms_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o  <= 1'b0;
      cyc     <= '0;
      ms_left <= '0;
    end else if (go_i) begin
      busy_o  <= 1'b1;
      cyc     <= '0;
      ms_left <= (code_i == WT_LONG) ? MSW'(LONG_MS - 1) : MSW'(SHORT_MS - 1);
    end else if (busy_o) begin
      if (cyc == CYC_LAST) begin
        cyc <= '0;
        if (ms_left == '0) busy_o <= 1'b0;
        else ms_left <= ms_left - 1'b1;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end

endmodule

// File: rtl/disp_spi_xfer.sv
module disp_spi_xfer
  import disp_seq_pkg::*;
#(
  parameter int SCLK_HALF = 13
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go_i,
  input  logic [FRAME_BITS-1:0] word_i,
  output logic                  done_o,
  output logic [15:0]           rx_o,
  output logic                  sclk_o,
  output logic                  cs_n_o,
  output logic                  mosi_o,
  input  logic                  miso_i
);

  localparam int HW = $clog2(SCLK_HALF + 1);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [HW-1:0] H_LAST   = HW'(SCLK_HALF - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);

  typedef enum logic [2:0] {X_IDLE, X_LEAD, X_BITS, X_TRAIL, X_GAP} xst_e;

  xst_e                  st;
  logic [HW-1:0]         hcnt;
  logic [BW-1:0]         bcnt;
  logic [FRAME_BITS-1:0] sh;
  logic                  tick;

  assign tick = (hcnt == H_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= X_IDLE;
      hcnt   <= '0;
      bcnt   <= '0;
      sh     <= '0;
      rx_o   <= '0;
      sclk_o <= 1'b0;
      cs_n_o <= 1'b1;
      mosi_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      hcnt   <= tick ? '0 : hcnt + 1'b1;
      case (st)
        X_IDLE: begin
          hcnt <= '0;
          if (go_i) begin
            sh     <= word_i;
            mosi_o <= word_i[FRAME_BITS-1];
            cs_n_o <= 1'b0;
            bcnt   <= '0;
            st     <= X_LEAD;
          end
        end
        X_LEAD: if (tick) begin
          sclk_o <= 1'b1;
          rx_o   <= {rx_o[14:0], miso_i};
          st     <= X_BITS;
        end
        X_BITS: if (tick) begin
          if (sclk_o) begin
            sclk_o <= 1'b0;
            if (bcnt == BIT_LAST) begin
              st <= X_TRAIL;
            end else begin
              bcnt   <= bcnt + 1'b1;
              sh     <= sh << 1;
              mosi_o <= sh[FRAME_BITS-2];
            end
          end else begin
            sclk_o <= 1'b1;
            rx_o   <= {rx_o[14:0], miso_i};
          end
        end
        X_TRAIL: if (tick) begin
          cs_n_o <= 1'b1;
          st     <= X_GAP;
        end
        X_GAP: if (tick) begin
          done_o <= 1'b1;
          st     <= X_IDLE;
        end
        default: st <= X_IDLE;
      endcase
    end
  end

  // ---- checks on the serial pins ----
  logic          sclk_q;
  logic [HW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      held   <= HW'(SCLK_HALF);
    end else begin
      sclk_q <= sclk_o;
      if (sclk_o != sclk_q) begin
        assert_sclk_half_R8: assert (held >= HW'(SCLK_HALF))
          else $error("SCLK level shorter than SCLK_HALF");
        held <= HW'(1);
      end else if (held < HW'(SCLK_HALF)) begin
        held <= held + 1'b1;
      end
    end
  end

  assert_sclk_idle_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  assert_mosi_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

endmodule

// File: rtl/disp_init_seq.sv
module disp_init_seq
  import disp_seq_pkg::*;
#(
  parameter int   CLK_PER_MS  = 100000,
  parameter int   SCLK_HALF   = 13,
  parameter logic CHIP_ID_BIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic pwr_off_i,
  input  logic tx_inv_i,
  output logic busy_o,
  output logic done_o,
  output logic err_o,
  output logic sclk_o,
  output logic cs_n_o,
  output logic mosi_o,
  input  logic miso_i
);

  typedef enum logic [3:0] {
    S_IDLE, S_PROBE_IDX, S_PROBE_RD, S_CHECK,
    S_FETCH, S_IDX, S_DATA, S_WAIT
  } st_e;

  st_e                   state, after_send;
  logic [STEP_AW-1:0]    ptr;
  step_t                 step_q;
  logic                  issued, inv_q;
  logic                  x_go, x_done;
  logic [FRAME_BITS-1:0] x_word, tx_word;
  logic [15:0]           x_rx;
  logic                  wt_go, wt_busy;
  logic                  sending;

  disp_seq_rom u_rom (
    .clk  (clk),
    .addr (ptr),
    .q    (step_q)
  );

  disp_spi_xfer #(.SCLK_HALF(SCLK_HALF)) u_xfer (
    .clk    (clk),
    .rst    (rst),
    .go_i   (x_go),
    .word_i (x_word),
    .done_o (x_done),
    .rx_o   (x_rx),
    .sclk_o (sclk_o),
    .cs_n_o (cs_n_o),
    .mosi_o (mosi_o),
    .miso_i (miso_i)
  );

  disp_wait_timer #(.CLK_PER_MS(CLK_PER_MS)) u_wait (
    .clk    (clk),
    .rst    (rst),
    .go_i   (wt_go),
    .code_i (step_q.wt),
    .busy_o (wt_busy)
  );

  // frame content and successor for each sending state
  always_comb begin
    sending    = 1'b1;
    tx_word    = '0;
    after_send = S_IDLE;
    case (state)
      S_PROBE_IDX: begin
        tx_word    = {start_byte(CHIP_ID_BIT, 1'b0, 1'b0), 16'h0000};
        after_send = S_PROBE_RD;
      end
      S_PROBE_RD: begin
        tx_word    = {start_byte(CHIP_ID_BIT, 1'b1, 1'b1), 16'h0000};
        after_send = S_CHECK;
      end
      S_IDX: begin
        tx_word    = {start_byte(CHIP_ID_BIT, 1'b0, 1'b0), 8'h00, step_q.idx};
        after_send = step_q.idx_only ? S_WAIT : S_DATA;
      end
      S_DATA: begin
        tx_word    = {start_byte(CHIP_ID_BIT, 1'b1, 1'b0), step_q.val};
        after_send = S_WAIT;
      end
      default: sending = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      ptr    <= '0;
      issued <= 1'b0;
      inv_q  <= 1'b0;
      x_go   <= 1'b0;
      x_word <= '0;
      wt_go  <= 1'b0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      x_go  <= 1'b0;
      wt_go <= 1'b0;
      if (sending) begin
        if (!issued) begin
          x_go   <= 1'b1;
          x_word <= inv_q ? ~tx_word : tx_word;
          issued <= 1'b1;
        end else if (x_done) begin
          issued <= 1'b0;
          state  <= after_send;
          if (after_send == S_WAIT) wt_go <= (step_q.wt != WT_NONE);
        end
      end else begin
        case (state)
          S_IDLE: begin
            if (start_i || pwr_off_i) begin
              inv_q  <= tx_inv_i;
              busy_o <= 1'b1;
              done_o <= 1'b0;
              err_o  <= 1'b0;
            end
            if (start_i) begin
              state <= S_PROBE_IDX;
            end else if (pwr_off_i) begin
              ptr   <= STEP_AW'(PWROFF_BASE);
              state <= S_FETCH;
            end
          end
          S_CHECK: begin
            if ((x_rx & CODE_MASK) == CODE_EXPECT) begin
              ptr   <= '0;
              state <= S_FETCH;
            end else begin
              err_o  <= 1'b1;
              busy_o <= 1'b0;
              state  <= S_IDLE;
            end
          end
          S_FETCH: state <= S_IDX;
          S_WAIT: begin
            if (!wt_go && !wt_busy) begin
              if (step_q.last) begin
                busy_o <= 1'b0;
                done_o <= 1'b1;
                state  <= S_IDLE;
              end else begin
                ptr   <= ptr + 1'b1;
                state <= S_FETCH;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // ---- sequencing checks ----
  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o));

  assert_cs_in_busy_R10: assert property (@(posedge clk) disable iff (rst)
    !cs_n_o |-> busy_o);

  assert_quiet_wait_R6: assert property (@(posedge clk) disable iff (rst)
    wt_busy |-> cs_n_o);

  assert_err_halts_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> (!busy_o && cs_n_o));

endmodule

// File: tb/disp_init_seq_tb_top.sv
module disp_init_seq_tb_top;

  localparam int MSC  = 20;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, pwr_off_i = 1'b0, tx_inv_i = 1'b0;
  logic busy_o, done_o, err_o, sclk_o, cs_n_o, mosi_o, miso_i;

  always #5 clk = ~clk;

  disp_init_seq #(.CLK_PER_MS(MSC), .SCLK_HALF(HALF), .CHIP_ID_BIT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .pwr_off_i(pwr_off_i),
    .tx_inv_i(tx_inv_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  // ---- controller model: records frames and returns a device code ----
  longint      cyc = 0;
  int          nchk = 0, nfail = 0;
  int          nfr = 0;
  int          k = 0;
  logic [23:0] fr [512];
  longint      tf [512];
  longint      tr [512];
  logic [23:0] s_in = '0;
  logic [15:0] resp_code = 16'h9221;
  logic [23:0] resp24;

  always @(posedge clk) cyc <= cyc + 1;

  assign resp24 = {8'h00, resp_code};
  assign miso_i = (k < 24) ? resp24[23-k] : 1'b0;

  always @(posedge sclk_o or negedge cs_n_o) begin
    if (!sclk_o) begin
      k     = 0;
      s_in  = '0;
      tf[nfr] = cyc;
    end else if (!cs_n_o) begin
      s_in = {s_in[22:0], mosi_o};
      k    = k + 1;
    end
  end

  always @(posedge cs_n_o) begin
    if (!rst) begin
      fr[nfr] = s_in;
      tr[nfr] = cyc;
      nfr     = nfr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic inv);
    @(negedge clk); tx_inv_i = inv; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_end(output longint t_end);
    while (!(done_o || err_o)) @(negedge clk);
    t_end = cyc;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && err_o == 0, "R1", "flags after reset",
        {busy_o, done_o, err_o}, 0);
    chk(cs_n_o == 1 && sclk_o == 0, "R1", "serial idle after reset", {cs_n_o, sclk_o}, 2);
  endtask

  task automatic t_init_normal;
    int b; longint te;
    b = nfr; resp_code = 16'h9221;
    pulse_start(1'b0);
    wait_end(te);
    chk(nfr - b == 77, "R5", "frame count", nfr - b, 77);
    chk(fr[b] == 24'h740000, "R2", "probe index frame", fr[b], 24'h740000);
    chk(fr[b+1] == 24'h770000, "R2", "probe read frame", fr[b+1], 24'h770000);
    chk(fr[b+2] == 24'h740000, "R4", "first write index", fr[b+2], 24'h740000);
    chk(fr[b+3] == 24'h760001, "R4", "first write data", fr[b+3], 24'h760001);
    chk(fr[b+32] == 24'h740056, "R5", "hidden reg index", fr[b+32], 24'h740056);
    chk(fr[b+33] == 24'h76080F, "R5", "hidden reg data", fr[b+33], 24'h76080F);
    chk(fr[b+75] == 24'h76DB00, "R5", "last data frame", fr[b+75], 24'h76DB00);
    chk(fr[b+76] == 24'h740022, "R5", "final select frame", fr[b+76], 24'h740022);
    chk(tf[b+4] - tr[b+3] >= 10*MSC, "R6", "pause after reg 00", tf[b+4] - tr[b+3], 10*MSC);
    chk(tf[b+26] - tr[b+25] >= 10*MSC, "R6", "pause after reg 10", tf[b+26] - tr[b+25], 10*MSC);
    chk(tf[b+28] - tr[b+27] < 10*MSC, "R6", "no pause after reg 11", tf[b+28] - tr[b+27], 0);
    chk(tf[b+30] - tr[b+29] >= 40*MSC, "R6", "pause after reg 12", tf[b+30] - tr[b+29], 40*MSC);
    chk(tf[b+32] - tr[b+31] >= 40*MSC, "R6", "pause after reg 13", tf[b+32] - tr[b+31], 40*MSC);
    chk(tr[b+5] - tf[b+5] >= 48*HALF, "R8", "frame length", tr[b+5] - tf[b+5], 48*HALF);
    chk(done_o == 1 && err_o == 0 && busy_o == 0, "R11", "end flags",
        {busy_o, done_o, err_o}, 3'b010);
    chk(cs_n_o == 1 && sclk_o == 0, "R8", "serial idle after run", {cs_n_o, sclk_o}, 2);
  endtask

  task automatic t_bad_id;
    int b; longint te;
    b = nfr; resp_code = 16'h9230;
    pulse_start(1'b0);
    chk(done_o == 0, "R11", "done cleared on accept", done_o, 0);
    wait_end(te);
    chk(err_o == 1 && busy_o == 0 && done_o == 0, "R3", "error flags",
        {busy_o, done_o, err_o}, 3'b001);
    repeat (200) @(negedge clk);
    chk(nfr - b == 2, "R3", "frames after mismatch", nfr - b, 2);
  endtask

  task automatic t_invert;
    int b; longint te;
    b = nfr; resp_code = 16'h922F;
    pulse_start(1'b1);
    chk(err_o == 0, "R11", "error cleared on accept", err_o, 0);
    wait_end(te);
    chk(fr[b] == 24'h8BFFFF, "R9", "inverted probe index", fr[b], 24'h8BFFFF);
    chk(fr[b+1] == 24'h88FFFF, "R9", "inverted probe read", fr[b+1], 24'h88FFFF);
    chk(fr[b+3] == 24'h89FFFE, "R9", "inverted data frame", fr[b+3], 24'h89FFFE);
    chk(nfr - b == 77 && done_o == 1, "R3", "masked code accepted", nfr - b, 77);
    @(negedge clk); tx_inv_i = 1'b0;
  endtask

  task automatic t_pwroff;
    int b; longint te;
    b = nfr;
    @(negedge clk); pwr_off_i = 1'b1;
    @(negedge clk); pwr_off_i = 1'b0;
    wait_end(te);
    chk(nfr - b == 8, "R7", "shutdown frame count", nfr - b, 8);
    chk(fr[b] == 24'h740010, "R7", "shutdown first index", fr[b], 24'h740010);
    chk(fr[b+1] == 24'h760000, "R7", "shutdown data", fr[b+1], 24'h760000);
    chk(fr[b+6] == 24'h740013, "R7", "shutdown last index", fr[b+6], 24'h740013);
    chk(tf[b+2] - tr[b+1] >= 10*MSC, "R7", "pause after reg 10", tf[b+2] - tr[b+1], 10*MSC);
    chk(te - tr[b+7] >= 40*MSC, "R7", "pause before done", te - tr[b+7], 40*MSC);
    chk(done_o == 1, "R7", "done after shutdown", done_o, 1);
  endtask

  task automatic t_busy_ignore;
    int b; longint te;
    b = nfr; resp_code = 16'h9222;
    pulse_start(1'b0);
    while (nfr < b + 10) @(negedge clk);
    @(negedge clk); start_i = 1'b1; pwr_off_i = 1'b1;
    @(negedge clk); start_i = 1'b0; pwr_off_i = 1'b0;
    wait_end(te);
    repeat (200) @(negedge clk);
    chk(nfr - b == 77, "R10", "frames with requests during run", nfr - b, 77);
    chk(fr[b+76] == 24'h740022, "R10", "sequence ends normally", fr[b+76], 24'h740022);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_init_normal();
    t_bad_id();
    t_invert();
    t_pwroff();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule